// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block moves one byte at a time over an I2C bus as its single master. A processor-style port writes a byte into the data buffer, and that write alone starts the transfer. The engine clocks the byte out MSB first. It then releases SDA for the ninth clock, samples the target's acknowledge at the ninth falling edge, raises a sticky interrupt flag, and parks with SCL held low until the next command.

A separate receive command clocks eight bits in from the target, MSB first. The byte goes into the same buffer, and the engine parks with SCL low. A reloadable baud counter sets the length of every SCL low and high phase. Status flags report:

- buffer full
- write collision
- receive overflow
- acknowledge status
- completion

The block drives the open-drain lines through active-high pull-down enables and reads SDA back through a sample input. START, STOP, repeated START, master acknowledge after reception, clock stretching and arbitration are handled outside this block.

Top module: `i2c_byte_engine`

## Requirements
- R1: A synchronous reset returns the engine to idle. Both pull-down enables are released, and buffer full, write collision, overflow, acknowledge status and interrupt all read 0.
- R2: A buffer write while idle loads the byte, sets buffer full and starts a transmit on the next cycle. Data bits appear on SDA MSB first, one bit per SCL clock.
- R3: Every SCL low phase and every SCL high phase lasts P clock cycles, where P equals the baud reload value, or 1 when the reload value is 0.
- R4: SDA driven by the engine never changes while SCL is released high. Data bits change together with the SCL falling edge.
- R5: In transmit, at the eighth SCL falling edge, buffer full clears and the engine releases SDA.
- R6: At the ninth SCL falling edge, SDA is sampled into the acknowledge status: 0 when the line is low (ACK) and 1 when it is high (NACK). The interrupt flag is then set. SCL stays held low with SDA released, and no further clocks occur until the next command.
- R7: A receive command is accepted only while idle, and rx_active then reads 1. A receive command given during a transfer, or in the same cycle as a buffer write, is ignored.
- R8: In receive, SDA is sampled at each SCL falling edge, and the first bit becomes the MSB. After the eighth falling edge, rx_active clears, the byte appears on rd_data, buffer full and interrupt are set, and SCL stays held low.
- R9: A read strobe clears buffer full whenever no transmit is in progress.
- R10: A received byte that completes while buffer full is still set raises the overflow flag and leaves the buffer holding the earlier byte. Only an overflow clear strobe clears the flag.
- R11: A buffer write during any transfer sets the write-collision flag and leaves both the buffer and the running transfer unchanged. Only a collision clear strobe clears the flag.
- R12: The interrupt flag stays set until a clear strobe. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_reload | input | BAUD_W | Phase length in clock cycles (0 acts as 1) |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | BYTE_W | Byte to write |
| rd_en | input | 1 | Buffer read strobe |
| rcv_go | input | 1 | Receive command strobe |
| clr_wcol | input | 1 | Clear write-collision flag |
| clr_ovf | input | 1 | Clear overflow flag |
| clr_irq | input | 1 | Clear interrupt flag |
| rd_data | output | BYTE_W | Buffer contents |
| buf_full | output | 1 | Buffer full flag |
| wcol | output | 1 | Write-collision flag |
| ovf | output | 1 | Receive overflow flag |
| ack_nack | output | 1 | Acknowledge status, 1 = NACK |
| irq | output | 1 | Sticky transfer-complete flag |
| rx_active | output | 1 | Receive in progress |
| scl_lo | output | 1 | Pull SCL low when 1 |
| sda_lo | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench counts the length of every SCL phase with a reload of 4 and with a reload of 0. An engine that lets the counter drift would stretch or shorten phases, and one that mishandles a zero reload would hang or run unbounded. The bench watches SDA while SCL is high, so a bit that changes late would be reported as a data change during a high phase. It writes the buffer during a transfer and sends receive commands while busy, which catches an engine that corrupts the byte in flight or starts a second transfer. Two back-to-back receptions without a read must raise overflow and keep the first byte; an engine that overwrites the buffer would show the second byte instead.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (reload == '0) ? CNT_W'(1) : reload;
        tick  = run && (cnt_q >= limit - CNT_W'(1));
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: an idle counter always restarts a phase from zero
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
    import i2c_eng_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output logic              busy,
    output logic              tx_mode,
    output logic              rx_mode,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              tx_release,
    output logic              tx_done,
    output logic              rx_done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int unsigned IDX_W = $clog2(BYTE_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(BYTE_W);

    typedef struct packed {
        seq_state_e        st;
        logic              scl_lo;
        logic              sda_lo;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] sh;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d          = q;
        tx_release = 1'b0;
        tx_done    = 1'b0;
        rx_done    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_tx) begin
                    d.st     = ST_TX;
                    d.scl_lo = 1'b1;
                    d.sda_lo = ~tx_byte[BYTE_W-1];
                    d.sh     = tx_byte;
                    d.idx    = '0;
                end else if (start_rx) begin
                    d.st     = ST_RX;
                    d.scl_lo = 1'b1;
                    d.sda_lo = 1'b0;
                    d.sh     = '0;
                    d.idx    = '0;
                end
            end
            ST_TX: begin
                if (tick) begin
                    if (q.scl_lo) begin
                        d.scl_lo = 1'b0;
                    end else begin
                        d.scl_lo = 1'b1;
                        if (q.idx < LAST_IDX) begin
                            d.idx    = q.idx + 1'b1;
                            d.sh     = {q.sh[BYTE_W-2:0], 1'b0};
                            d.sda_lo = ~q.sh[BYTE_W-2];
                        end else if (q.idx == LAST_IDX) begin
                            d.idx      = ACK_IDX;
                            d.sda_lo   = 1'b0;
                            tx_release = 1'b1;
                        end else begin
                            d.st    = ST_IDLE;
                            tx_done = 1'b1;
                        end
                    end
                end
            end
            ST_RX: begin
                if (tick) begin
                    if (q.scl_lo) begin
                        d.scl_lo = 1'b0;
                    end else begin
                        d.scl_lo = 1'b1;
                        d.sh     = {q.sh[BYTE_W-2:0], sda_in};
                        if (q.idx == LAST_IDX) begin
                            d.st    = ST_IDLE;
                            rx_done = 1'b1;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, scl_lo: 1'b0, sda_lo: 1'b0, idx: '0, sh: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign tx_mode = (q.st == ST_TX);
    assign rx_mode = (q.st == ST_RX);
    assign scl_lo  = q.scl_lo;
    assign sda_lo  = q.sda_lo;
    assign rx_byte = {q.sh[BYTE_W-2:0], sda_in};

    // R3: SCL moves during a transfer only on a baud rollover
    a_r3_scl_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(scl_lo));

    // R4: SDA is frozen while SCL is released
    a_r4_sda_hold: assert property (@(posedge clk) disable iff (rst)
        !scl_lo |=> (scl_lo || $stable(sda_lo)));

    // R5: the line is freed for the target after the last data bit
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        tx_release |=> (!sda_lo && scl_lo));

    // R6: an idle engine never pulls SDA
    a_r6_idle_sda: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_lo);

    // R6: completion parks SCL low
    a_r6_park_low: assert property (@(posedge clk) disable iff (rst)
        (tx_done || rx_done) |=> (scl_lo && !busy));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rcv_go,
    input  logic              clr_wcol,
    input  logic              clr_ovf,
    input  logic              clr_irq,
    output logic [BYTE_W-1:0] rd_data,
    output logic              buf_full,
    output logic              wcol,
    output logic              ovf,
    output logic              ack_nack,
    output logic              irq,
    output logic              rx_active,
    output logic              scl_lo,
    output logic              sda_lo,
    input  logic              sda_in
);

    typedef struct packed {
        logic [BYTE_W-1:0] buf_byte;
        logic              full;
        logic              wcol;
        logic              ovf;
        logic              ack;
        logic              irq;
    } eng_regs_t;

    eng_regs_t q, d;

    logic              tick;
    logic              busy, tx_mode, rx_mode;
    logic              start_tx, start_rx;
    logic              tx_release, tx_done, rx_done;
    logic [BYTE_W-1:0] rx_byte;

    assign start_tx = wr_en && !busy;
    assign start_rx = rcv_go && !busy && !wr_en;

    i2c_baud_tick #(.CNT_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .reload (baud_reload),
        .tick   (tick)
    );

    i2c_bit_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start_tx   (start_tx),
        .start_rx   (start_rx),
        .tx_byte    (wr_data),
        .sda_in     (sda_in),
        .busy       (busy),
        .tx_mode    (tx_mode),
        .rx_mode    (rx_mode),
        .scl_lo     (scl_lo),
        .sda_lo     (sda_lo),
        .tx_release (tx_release),
        .tx_done    (tx_done),
        .rx_done    (rx_done),
        .rx_byte    (rx_byte)
    );

    always_comb begin
        d = q;
        if (clr_wcol) d.wcol = 1'b0;
        if (clr_ovf)  d.ovf  = 1'b0;
        if (clr_irq)  d.irq  = 1'b0;
        if (rd_en && !tx_mode) d.full = 1'b0;
        if (start_tx) begin
            d.buf_byte = wr_data;
            d.full     = 1'b1;
        end
        if (wr_en && busy) d.wcol = 1'b1;
        if (tx_release) d.full = 1'b0;
        if (tx_done) begin
            d.ack = sda_in;
            d.irq = 1'b1;
        end
        if (rx_done) begin
            if (d.full) begin
                d.ovf = 1'b1;
            end else begin
                d.buf_byte = rx_byte;
            end
            d.full = 1'b1;
            d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{buf_byte: '0, full: 1'b0, wcol: 1'b0, ovf: 1'b0, ack: 1'b0, irq: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_data   = q.buf_byte;
    assign buf_full  = q.full;
    assign wcol      = q.wcol;
    assign ovf       = q.ovf;
    assign ack_nack  = q.ack;
    assign irq       = q.irq;
    assign rx_active = rx_mode;

    // R11: a write during a transfer flags a collision and keeps the buffer
    a_r11_collision: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !rx_done) |=> (wcol && $stable(rd_data)));

    // R10: a byte finishing on a full buffer raises overflow and keeps the old byte
    a_r10_overflow: assert property (@(posedge clk) disable iff (rst)
        (rx_done && buf_full && !rd_en) |=> (ovf && $stable(rd_data)));

    // R12: interrupt is sticky
    a_r12_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_irq) |=> irq);

    // R7: receive command during a transmit does not start a receive
    a_r7_rx_ignored: assert property (@(posedge clk) disable iff (rst)
        (rcv_go && tx_mode) |=> !rx_active);

    // R2: an accepted write starts a transmit with buffer full
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        start_tx |=> (buf_full && scl_lo && !rx_active));

endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;

    localparam int BYTE_W = 8;
    localparam int BAUD_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [BAUD_W-1:0] baud_reload = 8'd4;
    logic              wr_en = 1'b0;
    logic [BYTE_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              rcv_go = 1'b0;
    logic              clr_wcol = 1'b0;
    logic              clr_ovf = 1'b0;
    logic              clr_irq = 1'b0;
    logic [BYTE_W-1:0] rd_data;
    logic              buf_full, wcol, ovf, ack_nack, irq, rx_active;
    logic              scl_lo, sda_lo, sda_in;

    logic              slv_pull = 1'b0;
    logic              slv_ack = 1'b1;
    logic              slv_rx = 1'b0;
    logic [7:0]        slv_byte = '0;

    assign sda_in = ~(sda_lo | slv_pull);

    always #5 clk = ~clk;

    i2c_byte_engine #(.BYTE_W(BYTE_W), .BAUD_W(BAUD_W)) i_i2c_byte_engine (
        .clk(clk), .rst(rst), .baud_reload(baud_reload),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rcv_go(rcv_go),
        .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .clr_irq(clr_irq),
        .rd_data(rd_data), .buf_full(buf_full), .wcol(wcol), .ovf(ovf),
        .ack_nack(ack_nack), .irq(irq), .rx_active(rx_active),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int tim_err = 0;
    int stab_err = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Target model and monitor, sampled mid-cycle
    int   rise_cnt = 0;
    int   hi_len = 0;
    int   lo_len = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;
    logic [7:0] obs = '0;

    always @(negedge clk) begin
        logic scl_now, sda_now;
        logic [7:0] e;
        int p;
        p = (baud_reload == 0) ? 1 : int'(baud_reload);
        scl_now = ~scl_lo;
        sda_now = sda_in;
        if (rst) begin
            rise_cnt = 0; slv_pull = 1'b0; prev_scl = 1'b1; hi_len = 0; lo_len = 0;
        end else begin
            if (!prev_scl && scl_now) begin
                if (rise_cnt >= 1 && lo_len != p) tim_err++;
                rise_cnt++;
                hi_len = 1;
                if (!slv_rx && rise_cnt <= 8) obs = {obs[6:0], sda_now};
                if (!slv_rx && rise_cnt == 8)
                    chk(buf_full == 1'b1, "R5", "buf_full before 8th fall", buf_full, 1);
            end else if (prev_scl && !scl_now) begin
                if (rise_cnt >= 1 && hi_len != p) tim_err++;
                lo_len = 1;
                if (!slv_rx) begin
                    if (rise_cnt == 8) begin
                        chk(!buf_full && !sda_lo, "R5", "buf_full|sda_lo at 8th fall",
                            {buf_full, sda_lo}, 0);
                        slv_pull = slv_ack;
                    end else if (rise_cnt == 9) begin
                        slv_pull = 1'b0;
                        rise_cnt = 0;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                        chk(obs == e, "R2", "byte seen on bus", obs, e);
                        chk(ack_nack == !slv_ack, "R6", "ack status", ack_nack, !slv_ack);
                        chk(irq == 1'b1, "R6", "irq after 9th fall", irq, 1);
                        done_cnt++;
                    end
                end else begin
                    if (rise_cnt >= 1 && rise_cnt <= 7) begin
                        slv_pull = ~slv_byte[7 - rise_cnt];
                    end else if (rise_cnt == 8) begin
                        slv_pull = 1'b0;
                        rise_cnt = 0;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                        chk(rd_data == e, "R8", "received buffer", rd_data, e);
                        chk(buf_full && irq && !rx_active && scl_lo, "R8",
                            "full|irq|!active|scl_lo", {buf_full, irq, rx_active, scl_lo}, 4'b1101);
                        done_cnt++;
                    end
                end
            end else if (scl_now) begin
                hi_len++;
                if (sda_now != prev_sda) stab_err++;
            end else begin
                lo_len++;
            end
            prev_scl = scl_now;
            prev_sda = sda_now;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic strobe(ref logic s);
        @(posedge clk); #1;
        s = 1'b1;
        @(posedge clk); #1;
        s = 1'b0;
    endtask

    task automatic wait_done(input int target);
        wait (done_cnt >= target);
        step(2);
    endtask

    // Scoreboard driver: transmit one byte
    task automatic send(input logic [7:0] b, input logic ack);
        int t;
        t = done_cnt + 1;
        slv_rx = 1'b0; slv_ack = ack;
        exp_q.push_back(b);
        write_byte(b);
        wait_done(t);
    endtask

    // Scoreboard driver: receive one byte; exp is the buffer content expected
    task automatic receive(input logic [7:0] b, input logic [7:0] exp);
        int t;
        t = done_cnt + 1;
        slv_rx = 1'b1; slv_byte = b;
        exp_q.push_back(exp);
        @(negedge clk); slv_pull = ~b[7];
        strobe(rcv_go);
        #4;
        chk(rx_active == 1'b1, "R7", "receive accepted while idle", rx_active, 1);
        wait_done(t);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
            summary();
        end
    end

    initial begin
        int t;
        step(3);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_lo && !sda_lo && !buf_full && !wcol && !ovf && !ack_nack && !irq,
            "R1", "state after reset", {scl_lo, sda_lo, buf_full, wcol, ovf, ack_nack, irq}, 0);

        send(8'hA5, 1'b1);
        chk(tim_err == 0, "R3", "phase length errors P=4", tim_err, 0);
        chk(stab_err == 0, "R4", "SDA change while SCL high", stab_err, 0);
        t = done_cnt;
        step(20);
        chk(scl_lo && !sda_lo && done_cnt == t && rise_cnt == 0, "R6", "parked low, no clocks",
            {scl_lo, sda_lo}, 2'b10);
        chk(irq == 1'b1, "R12", "irq sticky before clear", irq, 1);
        strobe(clr_irq);
        chk(irq == 1'b0, "R12", "irq after clear", irq, 0);

        send(8'h3C, 1'b0);
        strobe(clr_irq);

        // Collision and ignored receive command during a transmit
        t = done_cnt + 1;
        slv_rx = 1'b0; slv_ack = 1'b1;
        exp_q.push_back(8'h5A);
        write_byte(8'h5A);
        step(10);
        write_byte(8'hFF);
        @(negedge clk);
        chk(wcol == 1'b1, "R11", "collision flag", wcol, 1);
        chk(rd_data == 8'h5A, "R11", "buffer kept on collision", rd_data, 8'h5A);
        strobe(rcv_go);
        @(negedge clk);
        chk(rx_active == 1'b0, "R7", "receive ignored while busy", rx_active, 0);
        wait_done(t);
        step(10);
        chk(rx_active == 1'b0 && scl_lo && rise_cnt == 0, "R7", "no receive after transmit",
            rx_active, 0);
        chk(wcol == 1'b1, "R11", "collision flag held", wcol, 1);
        strobe(clr_wcol);
        chk(wcol == 1'b0, "R11", "collision flag cleared", wcol, 0);
        strobe(clr_irq);

        // Write and receive command in the same cycle: write wins
        t = done_cnt + 1;
        exp_q.push_back(8'hC3);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = 8'hC3; rcv_go = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; rcv_go = 1'b0;
        @(negedge clk);
        chk(rx_active == 1'b0, "R7", "write wins over receive command", rx_active, 0);
        wait_done(t);

        // Receive paths
        receive(8'h96, 8'h96);
        strobe(rd_en);
        chk(buf_full == 1'b0, "R9", "read clears buffer full", buf_full, 0);
        receive(8'h4B, 8'h4B);
        chk(ovf == 1'b0, "R10", "no overflow on first byte", ovf, 0);
        receive(8'hE1, 8'h4B);
        chk(ovf == 1'b1, "R10", "overflow raised", ovf, 1);
        chk(rd_data == 8'h4B, "R10", "buffer keeps earlier byte", rd_data, 8'h4B);
        strobe(clr_ovf);
        chk(ovf == 1'b0, "R10", "overflow cleared", ovf, 0);
        strobe(rd_en);
        strobe(clr_irq);

        // Zero reload behaves as one cycle
        baud_reload = 8'd0;
        tim_err = 0;
        send(8'h81, 1'b1);
        chk(tim_err == 0, "R3", "phase length errors P=1", tim_err, 0);
        baud_reload = 8'd3;
        send(8'h7E, 1'b0);
        chk(tim_err == 0 && stab_err == 0, "R3", "phase errors P=3", tim_err, 0);

        // Synchronous reset in the middle of a transfer
        slv_rx = 1'b0;
        write_byte(8'hF0);
        step(7);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        exp_q.delete();
        @(negedge clk);
        chk(!scl_lo && !sda_lo && !buf_full && !wcol && !irq && !ack_nack && !rx_active,
            "R1", "reset mid transfer", {scl_lo, sda_lo, buf_full, irq}, 0);

        summary();
    end

endmodule